// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Single-Byte Buffers

This block is a small asynchronous serial port that sits on a synchronous register bus. Software writes a byte into a one-entry transmit holding buffer. The transmitter moves it into a shift register and sends it on `txd` as a fixed frame: one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity. The receiver watches `rxd`, checks each start bit at its midpoint, samples the data bits at the middle of each bit, and places a good frame into a one-entry receive buffer. Software reads the byte from there.

The bus has no wait states. Read data is a combinational function of the address. Writes and read side effects take effect at the clock edge in which `bus_sel` is high. The block keeps four event flags: transmit taken, receive ready, transmit overrun and receive overrun. Each flag drives an interrupt line, gated by its own enable bit. A fourth line is the OR of the other three. The bit time is set in clock cycles by a divider register.

Top module: `mmio_uart`

## Requirements
- R1: After reset the state, control and interrupt registers read 0, the divider reads 16, `txd` is 1, and all four interrupt lines are 0.
- R2: With transmit enable (control bit 0) set, a byte written at offset 0x00 leaves on `txd` as a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts the effective divider in clock cycles. The line idles high.
- R3: A data write sets transmit-full (state bit 0). The bit clears when the byte moves into the shift register, and at that moment interrupt bit 0 (transmit taken) is set. While transmit enable is 0, the byte waits and `txd` stays high.
- R4: A data write while transmit-full is 1 sets transmit overrun (state bit 2 and interrupt bit 2). The new byte is discarded, so only the buffered byte is sent.
- R5: With receive enable (control bit 1) set, a valid frame sets receive-full (state bit 1) and interrupt bit 1. A read at offset 0x00 returns the byte in bits 7:0 and clears receive-full. Reads of other offsets have no side effect.
- R6: A frame that completes while receive-full is 1 sets receive overrun (state bit 3 and interrupt bit 3). The stored byte is kept.
- R7: A low pulse on `rxd` that is shorter than half a bit time is ignored.
- R8: A frame whose stop bit is 0 is dropped. The receiver then waits for `rxd` to return high before it looks for a new start bit.
- R9: While receive enable is 0, incoming frames are ignored.
- R10: Writing 1 to a bit of the interrupt register (offset 0x0C, bits 3:0) clears that flag. Writing 0 leaves it unchanged. The overrun bits in the state register (offset 0x04) are the same flags and clear with them.
- R11: `irq_tx`, `irq_rx` and `irq_ovr` assert when a flag and its enable are both 1. The pairs are: interrupt bit 0 with control bit 2, bit 1 with control bit 3, bit 2 with control bit 4, and bit 3 with control bit 5. `irq_any` is their OR. Clearing the enables does not clear the flags.
- R12: The divider register (offset 0x10) holds bits 20:0 and reads back as written. The control register is at offset 0x08. A divider value below 16 times the bits as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-taken interrupt |
| irq_rx | output | 1 | Receive-ready interrupt |
| irq_ovr | output | 1 | Overrun interrupt, either direction |
| irq_any | output | 1 | OR of the three interrupt lines |

## Verification
The assertions assume that a bus access is a single cycle with `bus_wr` stable during that cycle. They also assume that `rxd` may change in any cycle, since it passes through a two-stage synchronizer before any check looks at it. The bench drives bus signals only on falling clock edges and holds each access for exactly one cycle. It produces receive frames whose bit times are whole multiples of the programmed divider. Glitches and bad stop bits are created on purpose, as separate scenarios, and never overlap a register access that would race the receiver.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

    localparam int DATA_BITS = 8;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_IRQ  = 'h0C;
    localparam int OFS_DIV  = 'h10;

    localparam int CT_TX_EN   = 0;
    localparam int CT_RX_EN   = 1;
    localparam int CT_TX_IE   = 2;
    localparam int CT_RX_IE   = 3;
    localparam int CT_TXOV_IE = 4;
    localparam int CT_RXOV_IE = 5;
    localparam int CTRL_W     = 6;

    localparam int FL_TX   = 0;
    localparam int FL_RX   = 1;
    localparam int FL_TXOV = 2;
    localparam int FL_RXOV = 3;
    localparam int FLAG_W  = 4;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 hold_valid,
    input  logic [DATA_BITS-1:0] hold_byte,
    output logic                 take,
    output logic                 txd
);

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [BIT_W-1:0]      bitn;
        logic [DIV_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
    } tx_regs_t;

    localparam tx_regs_t TX_RST = '{sh: '1, default: '0};

    tx_regs_t r_d, r_q;

    assign take = en && hold_valid && !r_q.busy;
    assign txd  = r_q.busy ? r_q.sh[0] : 1'b1;

    always_comb begin
        r_d = r_q;
        if (take) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.bitn = '0;
            r_d.sh   = {1'b1, hold_byte, 1'b0};
        end else if (r_q.busy) begin
            if (r_q.cnt == div - DIV_W'(1)) begin
                r_d.cnt = '0;
                r_d.sh  = {1'b1, r_q.sh[FRAME_BITS-1:1]};
                if (r_q.bitn == LAST_BIT) begin
                    r_d.busy = 1'b0;
                end else begin
                    r_d.bitn = r_q.bitn + BIT_W'(1);
                end
            end else begin
                r_d.cnt = r_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TX_RST;
        else        r_q <= r_d;
    end

    // R2: a taken byte starts with a low start bit on the next cycle
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    // R2: the final slot of a frame is the high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.bitn == LAST_BIT) |-> txd);

endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 rxd,
    output logic                 done,
    output logic [DATA_BITS-1:0] data
);

    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    typedef struct packed {
        logic                 s1;
        logic                 s2;
        rx_state_e            st;
        logic [DIV_W-1:0]     cnt;
        logic [BIT_W-1:0]     bitn;
        logic [DATA_BITS-1:0] sh;
        logic                 done;
    } rx_regs_t;

    localparam rx_regs_t RX_RST = '{s1: 1'b1, s2: 1'b1, st: RX_IDLE, default: '0};

    rx_regs_t r_d, r_q;
    logic [DIV_W-1:0] half;
    logic line;

    assign half = div >> 1;
    assign line = r_q.s2;
    assign done = r_q.done;
    assign data = r_q.sh;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = rxd;
        r_d.s2   = r_q.s1;
        r_d.done = 1'b0;
        if (!en) begin
            r_d.st = RX_IDLE;
        end else begin
            case (r_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        r_d.st  = RX_START;
                        r_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (r_q.cnt == half - DIV_W'(1)) begin
                        r_d.cnt  = '0;
                        r_d.bitn = '0;
                        r_d.st   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + DIV_W'(1);
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt == div - DIV_W'(1)) begin
                        r_d.cnt = '0;
                        r_d.sh  = {line, r_q.sh[DATA_BITS-1:1]};
                        if (r_q.bitn == LAST_BIT) r_d.st = RX_STOP;
                        else                      r_d.bitn = r_q.bitn + BIT_W'(1);
                    end else begin
                        r_d.cnt = r_q.cnt + DIV_W'(1);
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt == div - DIV_W'(1)) begin
                        r_d.cnt = '0;
                        if (line) begin
                            r_d.done = 1'b1;
                            r_d.st   = RX_IDLE;
                        end else begin
                            r_d.st   = RX_HOLD;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + DIV_W'(1);
                    end
                end
                RX_HOLD: begin
                    if (line) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RX_RST;
        else        r_q <= r_d;
    end

    // R8: a frame is only delivered if the stop bit sampled high
    p_done_stop_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> $past(line));

    // R9: with the receiver disabled it rests in idle
    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (r_q.st == RX_IDLE && !r_q.done));

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W   = 21,
    parameter int MIN_DIV = 16,
    parameter int ADDR_W  = 5,
    parameter int BUS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr,
    output logic              irq_any
);

    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    typedef struct packed {
        logic [CTRL_W-1:0]    ctrl;
        logic [DIV_W-1:0]     div;
        logic [DATA_BITS-1:0] tx_hold;
        logic                 tx_full;
        logic [DATA_BITS-1:0] rx_byte;
        logic                 rx_full;
        logic [FLAG_W-1:0]    flags;
    } regs_t;

    localparam regs_t REG_RST = '{div: DIV_FLOOR, default: '0};

    regs_t r_d, r_q;

    logic wr_hit, rd_hit;
    logic wr_data, wr_ctrl, wr_irq, wr_div, rd_data;
    logic [DIV_W-1:0] eff_div;
    logic tx_take, rx_done;
    logic [DATA_BITS-1:0] rx_dat;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:DIV_W];

    assign wr_hit  = bus_sel && bus_wr;
    assign rd_hit  = bus_sel && !bus_wr;
    assign wr_data = wr_hit && (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_ctrl = wr_hit && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_irq  = wr_hit && (bus_addr == ADDR_W'(OFS_IRQ));
    assign wr_div  = wr_hit && (bus_addr == ADDR_W'(OFS_DIV));
    assign rd_data = rd_hit && (bus_addr == ADDR_W'(OFS_DATA));

    assign eff_div = (r_q.div < DIV_FLOOR) ? DIV_FLOOR : r_q.div;

    mmio_uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (r_q.ctrl[CT_TX_EN]),
        .div        (eff_div),
        .hold_valid (r_q.tx_full),
        .hold_byte  (r_q.tx_hold),
        .take       (tx_take),
        .txd        (txd)
    );

    mmio_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.ctrl[CT_RX_EN]),
        .div   (eff_div),
        .rxd   (rxd),
        .done  (rx_done),
        .data  (rx_dat)
    );

    always_comb begin
        r_d = r_q;
        if (wr_irq)  r_d.flags = r_q.flags & ~bus_wdata[FLAG_W-1:0];
        if (wr_ctrl) r_d.ctrl  = bus_wdata[CTRL_W-1:0];
        if (wr_div)  r_d.div   = bus_wdata[DIV_W-1:0];

        if (tx_take) begin
            r_d.tx_full      = 1'b0;
            r_d.flags[FL_TX] = 1'b1;
        end
        if (wr_data) begin
            if (r_q.tx_full) begin
                r_d.flags[FL_TXOV] = 1'b1;
            end else begin
                r_d.tx_hold = bus_wdata[DATA_BITS-1:0];
                r_d.tx_full = 1'b1;
            end
        end

        if (rd_data) r_d.rx_full = 1'b0;
        if (rx_done) begin
            if (r_q.rx_full && !rd_data) begin
                r_d.flags[FL_RXOV] = 1'b1;
            end else begin
                r_d.rx_byte      = rx_dat;
                r_d.rx_full      = 1'b1;
                r_d.flags[FL_RX] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_DATA): bus_rdata[DATA_BITS-1:0] = r_q.rx_byte;
            ADDR_W'(OFS_STAT): bus_rdata[3:0] = {r_q.flags[FL_RXOV], r_q.flags[FL_TXOV],
                                                 r_q.rx_full, r_q.tx_full};
            ADDR_W'(OFS_CTRL): bus_rdata[CTRL_W-1:0] = r_q.ctrl;
            ADDR_W'(OFS_IRQ):  bus_rdata[FLAG_W-1:0] = r_q.flags;
            ADDR_W'(OFS_DIV):  bus_rdata[DIV_W-1:0]  = r_q.div;
            default:           bus_rdata = '0;
        endcase
    end

    assign irq_tx  = r_q.flags[FL_TX] && r_q.ctrl[CT_TX_IE];
    assign irq_rx  = r_q.flags[FL_RX] && r_q.ctrl[CT_RX_IE];
    assign irq_ovr = (r_q.flags[FL_TXOV] && r_q.ctrl[CT_TXOV_IE]) ||
                     (r_q.flags[FL_RXOV] && r_q.ctrl[CT_RXOV_IE]);
    assign irq_any = irq_tx || irq_rx || irq_ovr;

    // R3: handing the byte to the shifter frees the buffer and raises the taken flag
    p_take_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_data) |=> (!r_q.tx_full && r_q.flags[FL_TX]));

    // R4: a write into a full buffer flags overrun and leaves the byte alone
    p_full_write_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && r_q.tx_full) |=> (r_q.flags[FL_TXOV] && $stable(r_q.tx_hold)));

    // R6: a frame landing on a full buffer flags overrun and keeps the old byte
    p_rx_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && r_q.rx_full && !rd_data) |=> (r_q.flags[FL_RXOV] && $stable(r_q.rx_byte)));

    // R11: writing all interrupt enables to 0 silences every line
    p_enables_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CT_RXOV_IE:CT_TX_IE] == '0) |=> !irq_any);

endmodule

// File: tb/test_mmio_uart.sv
`timescale 1ns/1ps
module test_mmio_uart;

    localparam logic [4:0] A_DATA = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_IRQ  = 5'h0C;
    localparam logic [4:0] A_DIV  = 5'h10;
    localparam int DIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq_tx, irq_rx, irq_ovr, irq_any;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mmio_uart i_mmio_uart (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_ovr(irq_ovr), .irq_any(irq_any)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // capture one frame from txd at the given bit time
    task automatic get_tx(int div, output logic [7:0] b, output logic ok);
        int waited = 0;
        ok = 1'b1;
        b  = '0;
        while (txd !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 4000) begin
            ok = 1'b0;
        end else begin
            repeat (div / 2) @(negedge clk);
            if (txd !== 1'b0) ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (div) @(negedge clk);
                b[i] = txd;
            end
            repeat (div) @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic send_rx(logic [7:0] b, logic stop_v, int extra_low);
        @(negedge clk);
        rxd = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (DIV) @(negedge clk);
        end
        rxd = stop_v;
        repeat (DIV) @(negedge clk);
        if (!stop_v) repeat (DIV * extra_low) @(negedge clk);
        rxd = 1'b1;
        repeat (DIV) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 txd idle", {31'b0, txd}, 32'h1);
        chk("R1 irq lines", {28'b0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'h0);
        rd_chk("R1 state", A_STAT, 32'h0);
        rd_chk("R1 control", A_CTRL, 32'h0);
        rd_chk("R1 interrupt", A_IRQ, 32'h0);
        rd_chk("R1 divider", A_DIV, 32'd16);
    endtask

    task automatic t_tx_hold();
        logic [7:0] b;
        logic ok;
        int lows = 0;
        wr(A_DATA, 32'h22);
        rd_chk("R3 full after write", A_STAT, 32'h1);
        idle(40);
        chk("R3 txd idle while disabled", {31'b0, txd}, 32'h1);
        rd_chk("R3 still full", A_STAT, 32'h1);
        wr(A_DATA, 32'h33);
        rd_chk("R4 overrun state", A_STAT, 32'h5);
        rd_chk("R4 overrun flag", A_IRQ, 32'h4);
        wr(A_CTRL, 32'h1);
        get_tx(DIV, b, ok);
        chk("R4 first byte sent", {23'b0, ok, b}, {23'b0, 1'b1, 8'h22});
        idle(DIV);
        rd_chk("R3 taken flag", A_IRQ, 32'h5);
        rd_chk("R3 buffer free", A_STAT, 32'h4);
        for (int i = 0; i < 30 * DIV; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R4 discarded byte not sent", lows, 0);
    endtask

    task automatic t_tx_frame();
        logic [7:0] b;
        logic ok;
        wr(A_CTRL, 32'h5);
        wr(A_IRQ, 32'hF);
        wr(A_DATA, 32'hA5);
        get_tx(DIV, b, ok);
        chk("R2 frame A5", {23'b0, ok, b}, {23'b0, 1'b1, 8'hA5});
        chk("R3 irq_tx after take", {31'b0, irq_tx}, 32'h1);
        idle(DIV);
        wr(A_DATA, 32'h6E);
        get_tx(DIV, b, ok);
        chk("R2 frame 6E", {23'b0, ok, b}, {23'b0, 1'b1, 8'h6E});
        idle(DIV);
    endtask

    task automatic t_div();
        logic [7:0] b;
        logic ok;
        wr(A_DIV, 32'hFFFF_FFFF);
        rd_chk("R12 divider field width", A_DIV, 32'h001F_FFFF);
        wr(A_DIV, 32'd20);
        rd_chk("R12 divider readback", A_DIV, 32'd20);
        wr(A_DATA, 32'hC9);
        get_tx(20, b, ok);
        chk("R12 frame at divider 20", {23'b0, ok, b}, {23'b0, 1'b1, 8'hC9});
        idle(20);
        wr(A_DIV, 32'd5);
        rd_chk("R12 small divider readback", A_DIV, 32'd5);
        wr(A_DATA, 32'h5B);
        get_tx(16, b, ok);
        chk("R12 small divider floored to 16", {23'b0, ok, b}, {23'b0, 1'b1, 8'h5B});
        idle(DIV);
        wr(A_DIV, 32'd16);
    endtask

    task automatic t_rx();
        wr(A_CTRL, 32'h0A);
        wr(A_IRQ, 32'hF);
        send_rx(8'h5A, 1'b1, 0);
        rd_chk("R5 receive full", A_STAT, 32'h2);
        rd_chk("R5 receive flag", A_IRQ, 32'h2);
        chk("R5 irq_rx", {31'b0, irq_rx}, 32'h1);
        rd_chk("R5 state read keeps full", A_STAT, 32'h2);
        rd_chk("R5 byte", A_DATA, 32'h5A);
        rd_chk("R5 full cleared by read", A_STAT, 32'h0);
    endtask

    task automatic t_rx_ovr();
        send_rx(8'h81, 1'b1, 0);
        send_rx(8'h42, 1'b1, 0);
        rd_chk("R6 overrun state", A_STAT, 32'hA);
        rd_chk("R6 overrun flag", A_IRQ, 32'hA);
        rd_chk("R6 old byte kept", A_DATA, 32'h81);
    endtask

    task automatic t_glitch();
        wr(A_IRQ, 32'hF);
        @(negedge clk);
        rxd = 1'b0;
        idle(4);
        rxd = 1'b1;
        idle(200);
        rd_chk("R7 short pulse ignored", A_STAT, 32'h0);
        send_rx(8'hC3, 1'b1, 0);
        rd_chk("R7 next frame intact", A_DATA, 32'hC3);
    endtask

    task automatic t_badstop();
        wr(A_IRQ, 32'hF);
        send_rx(8'h99, 1'b0, 3);
        idle(2 * DIV);
        rd_chk("R8 bad stop dropped", A_STAT, 32'h0);
        rd_chk("R8 no flag", A_IRQ, 32'h0);
        send_rx(8'h3E, 1'b1, 0);
        rd_chk("R8 recovers one frame", A_STAT, 32'h2);
        rd_chk("R8 recovered byte", A_DATA, 32'h3E);
    endtask

    task automatic t_rx_off();
        wr(A_CTRL, 32'h0);
        wr(A_IRQ, 32'hF);
        send_rx(8'h77, 1'b1, 0);
        rd_chk("R9 disabled state", A_STAT, 32'h0);
        rd_chk("R9 disabled flags", A_IRQ, 32'h0);
    endtask

    task automatic t_w1c();
        wr(A_CTRL, 32'h02);
        wr(A_IRQ, 32'hF);
        send_rx(8'h11, 1'b1, 0);
        send_rx(8'h12, 1'b1, 0);
        rd_chk("R10 flags before clear", A_IRQ, 32'hA);
        chk("R11 no lines without enables", {28'b0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'h0);
        wr(A_CTRL, 32'h0A);
        chk("R11 rx line", {28'b0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'b0101);
        wr(A_CTRL, 32'h2A);
        chk("R11 overrun line", {28'b0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'b0111);
        wr(A_CTRL, 32'h02);
        chk("R11 lines off", {28'b0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'h0);
        rd_chk("R11 flags kept after disable", A_IRQ, 32'hA);
        wr(A_IRQ, 32'h2);
        rd_chk("R10 clear one bit", A_IRQ, 32'h8);
        wr(A_IRQ, 32'h0);
        rd_chk("R10 zero write no effect", A_IRQ, 32'h8);
        rd_chk("R10 state shows overrun", A_STAT, 32'hA);
        wr(A_IRQ, 32'h8);
        rd_chk("R10 overrun cleared", A_IRQ, 32'h0);
        rd_chk("R10 state overrun cleared", A_STAT, 32'h2);
        rd_chk("R10 byte", A_DATA, 32'h11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_tx_hold();
        t_tx_frame();
        t_div();
        t_rx();
        t_rx_ovr();
        t_glitch();
        t_badstop();
        t_rx_off();
        t_w1c();
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule